// File: doc/BRIEF.md
# Time-Shared Stencil Multiply-Add Scheduler

This block computes one time step of a four-neighbour weighted 2D stencil over a vertical strip of a grid that sits in a local memory. Each new value is the weighted sum of the point's up, left, right and down neighbours, with one weight for each direction. The block has a single multiplier and a single adder, each with a latency equal to the strip width. A whole row of the strip is one batch, so each row goes through the multiplier four times, once per direction. The products come back around to the adder to build the partial sums, so both units stay busy.

A run starts with a one-cycle `start` pulse. The block latches the four weights, reads neighbours through the source read port (one cycle of read latency), and writes each finished value through the destination write port. It signals the end of the strip with a one-cycle `done`. Source and destination are separate memories. The user swaps them between time steps. Values are signed fixed point with `FRAC` fraction bits (Q8.8 by default).

Top module: `stencil_madd_sched`

## Requirements
- R1: Each written value is ((Cu*up + Cl*left) + Cr*right) + Cd*down, where each product and each addition follows R2 and R3, and the neighbours of point (row r, column c) are (r-1,c), (r,c-1), (r,c+1) and (r+1,c).
- R2: A product is rounded to nearest with halves going up: add 2^(FRAC-1) to the full product, then shift right arithmetically by FRAC.
- R3: Rounded products and every addition saturate to the signed DW-bit range (-32768..32767 by default).
- R4: A neighbour outside the strip counts as zero and is never read. One run performs exactly 4*ROWS*LANES - 2*ROWS - 2*LANES source reads.
- R5: One run writes every destination address exactly once. The address of point (r,c) is r*LANES + c, and no write occurs after `done`.
- R6: With the edge that samples an accepted `start` counted as edge 0, the write of point (r,c) is visible after edge 4*LANES*r + 5*LANES + 1 + c. Consecutive writes inside a row use consecutive addresses.
- R7: `done` is a one-cycle pulse visible after edge 4*LANES*ROWS + 2*LANES + 1, the cycle after the last write.
- R8: A `start` that arrives while a run is in progress has no effect: no extra reads, writes or `done` pulses.
- R9: The weights are captured on the edge that accepts `start`. Changing the weight inputs during a run does not alter its results.
- R10: After reset, `done`, `dst_wr_en` and `src_rd_en` are low.
- R11: An up-direction product is held exactly LANES cycles and meets the left-direction product of the same point. Each partial sum leaves the adder in the same cycle as the next product of that point, so row r+1 starts issuing right behind row r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| coef_up | input | DW | Weight of the upper neighbour |
| coef_left | input | DW | Weight of the left neighbour |
| coef_right | input | DW | Weight of the right neighbour |
| coef_down | input | DW | Weight of the lower neighbour |
| src_rd_en | output | 1 | Source memory read strobe |
| src_rd_addr | output | AW | Source memory read address |
| src_rd_data | input | DW | Source data, one cycle after the strobe |
| dst_wr_en | output | 1 | Destination write strobe |
| dst_wr_addr | output | AW | Destination write address |
| dst_wr_data | output | DW | Destination write data |
| done | output | 1 | One-cycle end-of-strip pulse |

## Verification
A uniform field with equal quarter weights separates the interior, where the result equals the input, from the edge and corner points, where the missing neighbours must read as zero. Random grids with random signed weights exercise the direction-to-weight pairing and the feedback alignment of the partial sums. A second time step computed from the previous result does the same with swapped memories. Tiny weights on small values isolate the rounding of the half cases, and full-scale values force the saturation of both products and sums. A run that receives a stray `start` and new weight values partway through shows whether the in-flight run ignores both.

// File: rtl/sms_pkg.sv
package sms_pkg;

  // Issue order of the four neighbour directions; the schedule depends on it.
  typedef enum logic [1:0] {PH_UP = 2'd0, PH_LEFT = 2'd1, PH_RIGHT = 2'd2, PH_DOWN = 2'd3} sms_phase_e;

  function automatic longint sms_clamp(longint v, int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Rounded, saturated fixed-point product.
  function automatic longint sms_mul(longint a, longint b, int w, int frac);
    longint p;
    p = a * b;
    p = p + (longint'(1) <<< (frac - 1));
    p = p >>> frac;
    return sms_clamp(p, w);
  endfunction

  // Saturated sum.
  function automatic longint sms_add(longint a, longint b, int w);
    return sms_clamp(a + b, w);
  endfunction

endpackage

// File: rtl/sms_delay.sv
module sms_delay #(
  parameter int W = 8,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (N == 0) begin : g_wire
      assign q = d;
    end else begin : g_sr
      logic [W-1:0] sr [N];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < N; i++) sr[i] <= '0;
        end else begin
          sr[0] <= d;
          for (int i = 1; i < N; i++) sr[i] <= sr[i-1];
        end
      end
      assign q = sr[N-1];
    end
  endgenerate
endmodule

// File: rtl/sms_arith_stage.sv
module sms_arith_stage #(
  parameter int DW     = 16,
  parameter int FRAC   = 8,
  parameter int TW     = 8,
  parameter int LAT    = 8,
  parameter bit IS_MUL = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic [TW-1:0]        tag_in,
  output logic signed [DW-1:0] y,
  output logic [TW-1:0]        tag_out
);
  import sms_pkg::*;

  logic signed [DW-1:0] a_q, b_q;
  logic [TW-1:0]        t_q;
  logic [DW-1:0]        y_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      t_q <= '0;
    end else begin
      a_q <= a;
      b_q <= b;
      t_q <= tag_in;
    end
  end

  generate
    if (IS_MUL) begin : g_mul
      assign y_c = DW'(sms_mul(longint'(a_q), longint'(b_q), DW, FRAC));
    end else begin : g_add
      assign y_c = DW'(sms_add(longint'(a_q), longint'(b_q), DW));
    end
  endgenerate

  logic [DW+TW-1:0] tail;
  sms_delay #(.W(DW + TW), .N(LAT - 1)) u_tail (
    .clk(clk), .rst_n(rst_n), .d({y_c, t_q}), .q(tail)
  );
  assign y       = tail[DW+TW-1:TW];
  assign tag_out = tail[TW-1:0];
endmodule

// File: rtl/sms_issue.sv
module sms_issue #(
  parameter int ROWS  = 16,
  parameter int LANES = 8,
  parameter int RW    = $clog2(ROWS),
  parameter int LW    = $clog2(LANES),
  parameter int AW    = RW + LW,
  parameter int TW    = 3 + RW + LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [TW-1:0] tag,
  output logic          blank
);
  import sms_pkg::*;

  localparam int CW   = LW + 2 + RW;
  localparam int LAST = ROWS * 4 * LANES - 1;

  logic          run;
  logic [CW-1:0] t;
  logic [LW-1:0] lane;
  logic [1:0]    ph;
  logic [RW-1:0] row;
  int            nr, nc;
  logic          inb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      t   <= '0;
    end else if (go) begin
      run <= 1'b1;
      t   <= '0;
    end else if (run) begin
      if (t == CW'(LAST)) run <= 1'b0;
      t <= t + 1'b1;
    end
  end

  assign lane = t[LW-1:0];
  assign ph   = t[LW+1:LW];
  assign row  = t[CW-1:LW+2];

  always_comb begin
    nr = int'(row);
    nc = int'(lane);
    unique case (sms_phase_e'(ph))
      PH_UP:    nr = nr - 1;
      PH_LEFT:  nc = nc - 1;
      PH_RIGHT: nc = nc + 1;
      default:  nr = nr + 1;
    endcase
    inb = (nr >= 0) && (nr < ROWS) && (nc >= 0) && (nc < LANES);
  end

  assign rd_en   = run && inb;
  assign rd_addr = inb ? AW'(nr * LANES + nc) : '0;
  assign tag     = {run, ph, row, lane};
  assign blank   = !inb;
endmodule

// File: rtl/stencil_madd_sched.sv
module stencil_madd_sched #(
  parameter int DW    = 16,
  parameter int FRAC  = 8,
  parameter int ROWS  = 16,
  parameter int LANES = 8,
  parameter int RW    = $clog2(ROWS),
  parameter int LW    = $clog2(LANES),
  parameter int AW    = RW + LW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [DW-1:0] coef_up,
  input  logic signed [DW-1:0] coef_left,
  input  logic signed [DW-1:0] coef_right,
  input  logic signed [DW-1:0] coef_down,
  output logic                 src_rd_en,
  output logic [AW-1:0]        src_rd_addr,
  input  logic signed [DW-1:0] src_rd_data,
  output logic                 dst_wr_en,
  output logic [AW-1:0]        dst_wr_addr,
  output logic signed [DW-1:0] dst_wr_data,
  output logic                 done
);
  import sms_pkg::*;

  // Pipeline depth equals strip width: this is what makes the rotation line up.
  localparam int DEPTH = LANES;
  localparam int TW    = 3 + RW + LW;   // {valid, phase[1:0], row, lane}

  logic                 busy, go, last_wr, done_q;
  logic signed [DW-1:0] coef_q [4];
  logic [TW-1:0]        iss_tag, r_tag;
  logic                 iss_blank, r_blank;

  assign go = start && !busy;

  sms_issue #(.ROWS(ROWS), .LANES(LANES), .RW(RW), .LW(LW), .AW(AW), .TW(TW)) u_issue (
    .clk(clk), .rst_n(rst_n), .go(go),
    .rd_en(src_rd_en), .rd_addr(src_rd_addr), .tag(iss_tag), .blank(iss_blank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done_q  <= 1'b0;
      r_tag   <= '0;
      r_blank <= 1'b1;
      for (int i = 0; i < 4; i++) coef_q[i] <= '0;
    end else begin
      if (go) begin
        busy      <= 1'b1;
        coef_q[0] <= coef_up;
        coef_q[1] <= coef_left;
        coef_q[2] <= coef_right;
        coef_q[3] <= coef_down;
      end else if (last_wr) begin
        busy <= 1'b0;
      end
      done_q  <= last_wr;
      r_tag   <= iss_tag;     // aligns the tag with the one-cycle memory read
      r_blank <= iss_blank;
    end
  end

  // Multiplier: operand from memory (or zero off-strip), weight picked by direction.
  logic signed [DW-1:0] m_a, m_b, m_y;
  logic [TW-1:0]        m_tag;
  assign m_a = r_blank ? '0 : src_rd_data;
  assign m_b = coef_q[r_tag[TW-2 -: 2]];

  sms_arith_stage #(.DW(DW), .FRAC(FRAC), .TW(TW), .LAT(DEPTH), .IS_MUL(1'b1)) u_mul (
    .clk(clk), .rst_n(rst_n), .a(m_a), .b(m_b), .tag_in(r_tag), .y(m_y), .tag_out(m_tag)
  );

  // Up-direction products wait one batch for their left-direction partners.
  logic signed [DW-1:0] u_y;
  logic [TW-1:0]        u_tag;
  logic [DW+TW-1:0]     u_word;
  sms_delay #(.W(DW + TW), .N(DEPTH)) u_upbuf (
    .clk(clk), .rst_n(rst_n), .d({m_y, m_tag}), .q(u_word)
  );
  assign u_y   = u_word[DW+TW-1:TW];
  assign u_tag = u_word[TW-1:0];

  // Adder operand select: first sum pairs with the buffered product, later
  // sums take the adder's own output back.
  logic signed [DW-1:0] s_b, a_y;
  logic [TW-1:0]        s_tag, a_tag;
  sms_phase_e           m_ph;
  assign m_ph = sms_phase_e'(m_tag[TW-2 -: 2]);

  always_comb begin
    s_b   = a_y;
    s_tag = m_tag;
    unique case (m_ph)
      PH_UP:   begin s_b = '0; s_tag[TW-1] = 1'b0; end
      PH_LEFT: s_b = u_tag[TW-1] ? u_y : '0;
      default: s_b = a_y;
    endcase
  end

  sms_arith_stage #(.DW(DW), .FRAC(FRAC), .TW(TW), .LAT(DEPTH), .IS_MUL(1'b0)) u_add (
    .clk(clk), .rst_n(rst_n), .a(m_y), .b(s_b), .tag_in(s_tag), .y(a_y), .tag_out(a_tag)
  );

  // Write-back when the down-direction sum leaves the adder.
  assign dst_wr_en   = a_tag[TW-1] && (sms_phase_e'(a_tag[TW-2 -: 2]) == PH_DOWN);
  assign dst_wr_addr = a_tag[RW+LW-1:0];
  assign dst_wr_data = a_y;
  assign last_wr     = dst_wr_en && (dst_wr_addr == AW'(ROWS * LANES - 1));
  assign done        = done_q;
endmodule

// File: rtl/sms_checker.sv
module sms_checker #(
  parameter int TW   = 10,
  parameter int LW   = 3,
  parameter int RW   = 4,
  parameter int AW   = 7,
  parameter int NPTS = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          dst_wr_en,
  input logic [AW-1:0] dst_wr_addr,
  input logic [TW-1:0] m_tag,
  input logic [TW-1:0] u_tag,
  input logic [TW-1:0] a_tag
);
  localparam int PL = RW + LW;

  AST_UP_MEETS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tag[TW-1] && m_tag[TW-2 -: 2] == 2'd1) |->
      (u_tag[TW-1] && u_tag[TW-2 -: 2] == 2'd0 && u_tag[PL-1:0] == m_tag[PL-1:0])); // R11

  AST_SUM_MEETS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tag[TW-1] && m_tag[TW-2 -: 2] >= 2'd2) |->
      (a_tag[TW-1] && a_tag[TW-2 -: 2] == 2'(m_tag[TW-2 -: 2] - 2'd1)
       && a_tag[PL-1:0] == m_tag[PL-1:0])); // R11

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(dst_wr_en) && $past(dst_wr_addr) == AW'(NPTS - 1))); // R7

  AST_NO_WRITE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !dst_wr_en); // R5

  AST_ROW_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr_en && $past(dst_wr_en)) |-> dst_wr_addr == AW'($past(dst_wr_addr) + 1'b1)); // R6
endmodule

bind stencil_madd_sched sms_checker #(
  .TW(TW), .LW(LW), .RW(RW), .AW(AW), .NPTS(ROWS * LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr),
  .m_tag(m_tag), .u_tag(u_tag), .a_tag(a_tag)
);

// File: tb/stencil_madd_sched_tb.sv
`timescale 1ns/1ps
module stencil_madd_sched_tb;
  localparam int DW = 16, ROWS = 16, LANES = 8, AW = 7, NP = ROWS * LANES;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic signed [DW-1:0] cu = '0, cl = '0, cr = '0, cd = '0;
  logic src_rd_en, dst_wr_en, done;
  logic [AW-1:0] src_rd_addr, dst_wr_addr;
  logic signed [DW-1:0] src_rd_data = '0, dst_wr_data;

  always #2 clk = ~clk;

  stencil_madd_sched u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .coef_up(cu), .coef_left(cl), .coef_right(cr), .coef_down(cd),
    .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
    .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data),
    .done(done)
  );

  int total = 0, bad = 0;
  int unsigned cyc = 0, s_cyc = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  bit mon_on = 1'b0;
  logic signed [DW-1:0] src_mem [NP];
  longint got [NP];
  longint expv [NP];
  bit wr_seen [NP];

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (src_rd_en) src_rd_data <= src_mem[src_rd_addr];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint bsat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint bmul(longint a, longint b);
    longint q;
    q = a * b + 128;
    if (q >= 0) return bsat(q / 256);
    return bsat(-((-q + 255) / 256));
  endfunction

  function automatic longint nb(int r, int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= LANES) return 0;
    return longint'(src_mem[r * LANES + c]);
  endfunction

  task automatic build_expect(longint ku, longint kl, longint kr, longint kd);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < LANES; c++) begin
        longint v;
        v = bsat(bmul(ku, nb(r - 1, c)) + bmul(kl, nb(r, c - 1)));
        v = bsat(v + bmul(kr, nb(r, c + 1)));
        v = bsat(v + bmul(kd, nb(r + 1, c)));
        expv[r * LANES + c] = v;
      end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (src_rd_en) rd_cnt++;
      if (done) done_cnt++;
      if (dst_wr_en) begin
        int n, r, c;
        n = int'(cyc - s_cyc) - 1;
        r = int'(dst_wr_addr) / LANES;
        c = int'(dst_wr_addr) % LANES;
        chk(n == 4 * LANES * r + 5 * LANES + 1 + c, "R6", "write edge", n, 4 * LANES * r + 5 * LANES + 1 + c);
        chk(!wr_seen[dst_wr_addr], "R5", "duplicate write", dst_wr_addr, -1);
        wr_seen[dst_wr_addr] = 1'b1;
        got[dst_wr_addr] = longint'(dst_wr_data);
        wr_cnt++;
      end
    end
  end

  task automatic do_run(string req, bit poke);
    bit seen;
    build_expect(longint'(cu), longint'(cl), longint'(cr), longint'(cd));
    for (int i = 0; i < NP; i++) wr_seen[i] = 1'b0;
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; mon_on = 1'b1;
    @(negedge clk);
    start = 1'b1;
    s_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      if (done) begin
        seen = 1'b1;
        chk(int'(cyc - s_cyc) - 1 == 4 * LANES * ROWS + 2 * LANES + 1, "R7", "done edge",
            int'(cyc - s_cyc) - 1, 4 * LANES * ROWS + 2 * LANES + 1);
      end else begin
        if (poke && k == 100) begin
          start = 1'b1;   // R8 stray start, R9 weight change mid-run
          cu = 16'sd300; cl = -16'sd77; cr = 16'sd5; cd = -16'sd400;
        end else if (poke && k == 101) begin
          start = 1'b0;
        end
        @(negedge clk);
      end
    end
    chk(seen, "R7", "watchdog: done never seen", 0, 1);
    repeat (60) @(negedge clk);
    mon_on = 1'b0;
    chk(wr_cnt == NP, "R5", "write count", wr_cnt, NP);
    chk(done_cnt == 1, poke ? "R8" : "R7", "done pulses", done_cnt, 1);
    chk(rd_cnt == 4 * NP - 2 * ROWS - 2 * LANES, poke ? "R8" : "R4", "read count", rd_cnt,
        4 * NP - 2 * ROWS - 2 * LANES);
    for (int i = 0; i < NP; i++)
      chk(got[i] == expv[i], req, "point value", got[i], expv[i]);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NP; i++) begin src_mem[i] = '0; got[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!done && !dst_wr_en && !src_rd_en, "R10", "outputs quiet in reset", {done, dst_wr_en, src_rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !dst_wr_en && !src_rd_en, "R10", "outputs quiet after reset", {done, dst_wr_en, src_rd_en}, 0);

    // R1 / R4: uniform field, quarter weights; edges reveal zero boundaries.
    for (int i = 0; i < NP; i++) src_mem[i] = 16'sd256;
    cu = 16'sd64; cl = 16'sd64; cr = 16'sd64; cd = 16'sd64;
    do_run("R1", 1'b0);

    // R1: random grid and signed weights.
    for (int i = 0; i < NP; i++) src_mem[i] = DW'(int'($urandom_range(1023)) - 512);
    cu = DW'(int'($urandom_range(511)) - 256); cl = DW'(int'($urandom_range(511)) - 256);
    cr = DW'(int'($urandom_range(511)) - 256); cd = DW'(int'($urandom_range(511)) - 256);
    do_run("R1", 1'b0);

    // R11: next time step with memories swapped.
    for (int i = 0; i < NP; i++) src_mem[i] = DW'(got[i]);
    do_run("R11", 1'b0);

    // R2: tiny weights expose rounding of half cases.
    for (int i = 0; i < NP; i++) src_mem[i] = DW'(int'($urandom_range(1023)) - 512);
    src_mem[0] = 16'sd128; src_mem[9] = -16'sd128; src_mem[20] = -16'sd129;
    cu = 16'sd1; cl = 16'sd1; cr = -16'sd1; cd = 16'sd1;
    do_run("R2", 1'b0);

    // R3: full-scale values saturate products and sums.
    for (int i = 0; i < NP; i++) src_mem[i] = (i % 3 == 0) ? -16'sd32768 : 16'sd32767;
    cu = 16'sd32767; cl = 16'sd32767; cr = -16'sd32768; cd = 16'sd20000;
    do_run("R3", 1'b0);

    // R9 / R8: stray start and weight change during the run.
    for (int i = 0; i < NP; i++) src_mem[i] = DW'(int'($urandom_range(2047)) - 1024);
    cu = 16'sd100; cl = -16'sd50; cr = 16'sd200; cd = 16'sd30;
    do_run("R9", 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule